// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

This peripheral keeps a calendar of seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-second tick input advances it. A second bank of the same seven fields holds an alarm time. Each alarm field can be compared or ignored, and a level interrupt output reports a match. Software reaches every register through a simple 32-bit register bus: a write strobe, an address and write data. Read data is a combinational decode of the address.

Out of reset the block is locked and the counter is stopped. Before any control, calendar, debounce or alarm write takes effect, seven key values must be written to seven key offsets in a fixed order. Software then sets the time while the stop bit is set, and clears the stop bit to let the calendar run. A whole roll-over, such as the last second of December 31st of year 99, updates every field on the same clock edge. A reader that takes seconds, then the other fields, then seconds again therefore sees a consistent snapshot whenever the two seconds readings agree.

Top module: `cal_rtc`

## Requirements
- R1: After reset the block is locked and the stop bit (offset 0x20, bit 0) reads 1. The time bank reads year 0, month 1, day of month 1, and 0 for day of week, hour, minute and second. Debounce, interrupt status, alarm control and `irq_o` all read 0.
- R2: The block unlocks after seven writes in this order: 0xC6 to 0x04, 0x9A to 0x08, 0x59 to 0x0C, 0xA3 to 0x10, 0x57 to 0x14, 0x67 to 0x18 and 0xD2 to 0x1C. Only data bits 7:0 are compared. Until then, writes to the control, debounce, time-bank and alarm registers leave them unchanged.
- R3: While locked, any write in the key window 0x04 to 0x1C that is not the next expected offset and value returns the sequence to its first step.
- R4: While the stop bit is 1, ticks do not change the time bank and the time fields can be written. While it is 0, a tick sampled on a clock edge advances the time by one second by that same edge, and writes to the time bank are ignored.
- R5: Field f of bank b is at offset 0x40 + 4*f + 0x20*b. Bank 0 is the live time and bank 1 is the alarm. The field order is year (f=0), month, day of month, day of week, hour, minute and second (f=6). A field reads back in data bits 7:0.
- R6: The roll-over rules are: second 59 to 0 carries into the minute, minute 59 to 0 carries into the hour, and hour 23 to 0 advances the day. A day advance moves the day of week 6 to 0 and ends the month after its last day with day 1. Every field changes in the one edge that takes the tick.
- R7: April, June, September and November have 30 days. February has 29 days when the year is a nonzero multiple of 4, and 28 days otherwise, year 0 included. The other months have 31 days.
- R8: Counting past December 31st 23:59:59 starts month 1, day 1. The year goes up by one, and year 99 wraps to year 0.
- R9: The debounce register at 0x2C holds bits 2:0 for read and write. Its other bits read 0.
- R10: The alarm control register is at 0x7C. Bit 0 is the master enable, and bit f+1 enables the compare of alarm field f. The status bit (0x30, bit 4) sets on the first advance whose new time equals the alarm in every compared field, and only while the master enable is 1.
- R11: Writing 1 to bit 4 of 0x30 clears the status bit. Writing 0 there leaves it unchanged.
- R12: `irq_o` is high exactly while both the status bit and the master enable are 1. Writing 0 to the alarm control register drops `irq_o` but leaves the status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second tick, one clock wide |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i |
| irq_o | output | 1 | Alarm interrupt, level |

## Verification
The assertions check the following on every cycle:
- The unlock can only complete on the last key write, and the block stays unlocked afterwards.
- While locked, writes leave the control and debounce state untouched.
- A stopped counter with no write holds its value, and every running tick moves the seconds.
- A tick that does not end a minute leaves the minutes alone.
- The status bit only rises after an enabled advance, an acknowledge without a concurrent advance clears it, and clearing the master enable drops the interrupt.

The bench scenarios show the parts that depend on calendar arithmetic and order:
- month lengths, the year-0 February, the year-99 wrap and the day-of-week wrap;
- a wrong key restarting the sequence;
- the alarm firing only on the first full match of its enabled fields, and not on a match of one field alone.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

  localparam int NUM_FIELDS   = 7;
  localparam int NUM_KEYS     = 7;
  localparam int CTL_W        = NUM_FIELDS + 1;
  localparam int FI_W         = $clog2(NUM_FIELDS);

  // calendar field indices (shared by the time and alarm banks)
  localparam int F_YEAR = 0;
  localparam int F_MON  = 1;
  localparam int F_DOM  = 2;
  localparam int F_DOW  = 3;
  localparam int F_HOUR = 4;
  localparam int F_MIN  = 5;
  localparam int F_SEC  = 6;

  // register offsets
  localparam int OFS_CTRL     = 'h20;
  localparam int OFS_DEBOUNCE = 'h2C;
  localparam int OFS_IRQ      = 'h30;
  localparam int OFS_ALM_CTL  = 'h7C;
  localparam int BANK_BASE    = 'h40;
  localparam int BANK_STRIDE  = 'h20;
  localparam int FIELD_STRIDE = 4;
  localparam int KEY_FIRST    = 'h04;
  localparam int KEY_LAST     = 'h1C;
  localparam int STAT_BIT     = 4;

  function automatic int key_offset(input int step);
    return KEY_FIRST + 4 * step;
  endfunction

  function automatic logic [7:0] key_value(input int step);
    case (step)
      0:       return 8'hC6;
      1:       return 8'h9A;
      2:       return 8'h59;
      3:       return 8'hA3;
      4:       return 8'h57;
      5:       return 8'h67;
      default: return 8'hD2;
    endcase
  endfunction

endpackage

// File: rtl/cal_rtc_unlock.sv
module cal_rtc_unlock
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              unlocked_o
);

  localparam int STEP_W = $clog2(NUM_KEYS + 1);
  localparam logic [STEP_W-1:0] STEP_DONE = STEP_W'(NUM_KEYS);
  localparam logic [ADDR_W-1:0] A_KFIRST = ADDR_W'(KEY_FIRST);
  localparam logic [ADDR_W-1:0] A_KLAST  = ADDR_W'(KEY_LAST);

  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;
  logic              in_window;
  logic              key_ok;

  assign unlocked_o = (step_q == STEP_DONE);
  assign in_window  = wr_i && (addr_i >= A_KFIRST) && (addr_i <= A_KLAST);
  assign key_ok     = (addr_i == ADDR_W'(key_offset(int'(step_q)))) &&
                      (wdata_i == key_value(int'(step_q)));
  assign step_en    = in_window && !unlocked_o;

  always_comb begin
    if (key_ok) step_d = step_q + STEP_W'(1);
    else        step_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  // R2: unlock completes only on the last key write in order
  assert_unlock_last_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_o) |-> $past(wr_i && addr_i == A_KLAST && wdata_i == 8'hD2))
    else $error("unlock rose without final key");

  // R2: once unlocked, stays unlocked
  assert_unlock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked_o |=> unlocked_o)
    else $error("unlock dropped");

endmodule

// File: rtl/cal_rtc_time.sv
module cal_rtc_time
  import cal_rtc_pkg::*;
#(
  parameter int FIELD_W  = 8,
  parameter int YEAR_MAX = 99
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 tick_i,
  input  logic                                 run_i,
  input  logic                                 wr_en_i,
  input  logic [FI_W-1:0]                      wr_field_i,
  input  logic [FIELD_W-1:0]                   wr_data_i,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0]   time_o,
  output logic                                 adv_o
);

  typedef logic [FIELD_W-1:0] fld_t;

  localparam fld_t ONE = FIELD_W'(1);

  logic [NUM_FIELDS-1:0][FIELD_W-1:0] time_q, time_d, nxt;
  logic time_en;
  logic adv;
  logic adv_q;
  logic c_sec, c_min, c_hour, c_day, c_mon;
  fld_t dim;

  function automatic fld_t month_days(input fld_t yr, input fld_t mo);
    logic leap;
    leap = (yr[1:0] == 2'b00) && (yr != '0);
    if (mo == FIELD_W'(2))
      return leap ? FIELD_W'(29) : FIELD_W'(28);
    else if (mo == FIELD_W'(4) || mo == FIELD_W'(6) ||
             mo == FIELD_W'(9) || mo == FIELD_W'(11))
      return FIELD_W'(30);
    else
      return FIELD_W'(31);
  endfunction

  assign adv = run_i && tick_i;
  assign dim = month_days(time_q[F_YEAR], time_q[F_MON]);

  // next calendar value: whole carry chain resolved in one cycle
  always_comb begin
    nxt    = time_q;
    c_sec  = time_q[F_SEC]  >= FIELD_W'(59);
    c_min  = c_sec  && (time_q[F_MIN]  >= FIELD_W'(59));
    c_hour = c_min  && (time_q[F_HOUR] >= FIELD_W'(23));
    c_day  = c_hour && (time_q[F_DOM]  >= dim);
    c_mon  = c_day  && (time_q[F_MON]  >= FIELD_W'(12));
    nxt[F_SEC] = c_sec ? '0 : time_q[F_SEC] + ONE;
    if (c_sec)  nxt[F_MIN]  = c_min  ? '0 : time_q[F_MIN] + ONE;
    if (c_min)  nxt[F_HOUR] = c_hour ? '0 : time_q[F_HOUR] + ONE;
    if (c_hour) begin
      nxt[F_DOW] = (time_q[F_DOW] >= FIELD_W'(6)) ? '0 : time_q[F_DOW] + ONE;
      nxt[F_DOM] = c_day ? ONE : time_q[F_DOM] + ONE;
    end
    if (c_day)  nxt[F_MON]  = c_mon ? ONE : time_q[F_MON] + ONE;
    if (c_mon)  nxt[F_YEAR] = (time_q[F_YEAR] >= FIELD_W'(YEAR_MAX)) ? '0
                                                                     : time_q[F_YEAR] + ONE;
  end

  always_comb begin
    time_d = nxt;
    if (wr_en_i) begin
      time_d = time_q;
      time_d[wr_field_i] = wr_data_i;
    end
  end

  assign time_en = adv || wr_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q         <= '0;
      time_q[F_MON]  <= ONE;
      time_q[F_DOM]  <= ONE;
    end else if (time_en) begin
      time_q <= time_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adv_q <= 1'b0;
    else        adv_q <= adv;
  end

  assign time_o = time_q;
  assign adv_o  = adv_q;

  // R4: stopped counter without a write holds
  assert_stop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_en_i) |=> $stable(time_q))
    else $error("time moved while stopped");

  // R4: every running tick moves the seconds
  assert_tick_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i) |=> !$stable(time_q[F_SEC]))
    else $error("tick did not advance seconds");

  // R6: a tick not ending a minute leaves minutes alone
  assert_no_false_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && time_q[F_SEC] < FIELD_W'(59)) |=> $stable(time_q[F_MIN]))
    else $error("minutes changed without carry");

endmodule

// File: rtl/cal_rtc_alarm.sv
module cal_rtc_alarm
  import cal_rtc_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] time_i,
  input  logic                               adv_i,
  input  logic                               bank_wr_i,
  input  logic [FI_W-1:0]                    bank_field_i,
  input  logic [FIELD_W-1:0]                 bank_data_i,
  input  logic                               ctl_wr_i,
  input  logic [CTL_W-1:0]                   ctl_data_i,
  input  logic                               ack_i,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm_o,
  output logic [CTL_W-1:0]                   ctl_o,
  output logic                               status_o,
  output logic                               irq_o
);

  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm_q, alm_d;
  logic [CTL_W-1:0]                   ctl_q;
  logic [NUM_FIELDS-1:0]              fld_ok;
  logic                               status_q, status_d, status_en;
  logic                               hit;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_cmp
    assign fld_ok[f] = !ctl_q[f+1] || (time_i[f] == alm_q[f]);
  end

  assign hit = adv_i && ctl_q[0] && (&fld_ok);

  always_comb begin
    alm_d = alm_q;
    alm_d[bank_field_i] = bank_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         alm_q <= '0;
    else if (bank_wr_i) alm_q <= alm_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctl_q <= '0;
    else if (ctl_wr_i) ctl_q <= ctl_data_i;
  end

  // set has priority over a same-cycle acknowledge
  assign status_d  = hit;
  assign status_en = hit || ack_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= 1'b0;
    else if (status_en) status_q <= status_d;
  end

  assign alarm_o  = alm_q;
  assign ctl_o    = ctl_q;
  assign status_o = status_q;
  assign irq_o    = status_q && ctl_q[0];

  // R10: status rises only after an enabled advance
  assert_status_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(adv_i && ctl_q[0]))
    else $error("status set without enabled advance");

  // R11: acknowledge without a concurrent advance clears status
  assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !adv_i) |=> !status_q)
    else $error("status survived acknowledge");

  // R12: clearing the master enable drops the interrupt
  assert_irq_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_i && !ctl_data_i[0]) |=> !irq_o)
    else $error("irq stayed after disable");

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int FIELD_W  = 8,
  parameter int YEAR_MAX = 99,
  parameter int DEB_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DEB  = ADDR_W'(OFS_DEBOUNCE);
  localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(OFS_IRQ);
  localparam logic [ADDR_W-1:0] A_ACTL = ADDR_W'(OFS_ALM_CTL);

  logic                               unlocked;
  logic                               stop_q, stop_d, stop_en;
  logic [DEB_W-1:0]                   deb_q, deb_d;
  logic                               deb_en;
  logic [NUM_FIELDS-1:0]              hit_time, hit_alm;
  logic [FI_W-1:0]                    fidx;
  logic                               time_wr, alm_wr, ctl_wr, ack;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] time_q, alm_q;
  logic                               adv;
  logic [CTL_W-1:0]                   ctl;
  logic                               status;
  logic [DATA_W-1:0]                  rdata;
  logic                               unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-1:8];

  cal_rtc_unlock #(.ADDR_W(ADDR_W)) u_unlock (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (bus_wr_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i[7:0]),
    .unlocked_o (unlocked)
  );

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_dec
    assign hit_time[f] = bus_addr_i == ADDR_W'(BANK_BASE + FIELD_STRIDE * f);
    assign hit_alm[f]  = bus_addr_i == ADDR_W'(BANK_BASE + BANK_STRIDE + FIELD_STRIDE * f);
  end

  always_comb begin
    fidx = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (hit_time[i] || hit_alm[i]) fidx = FI_W'(i);
    end
  end

  assign time_wr = bus_wr_i && unlocked && stop_q && (|hit_time);
  assign alm_wr  = bus_wr_i && unlocked && (|hit_alm);
  assign ctl_wr  = bus_wr_i && unlocked && (bus_addr_i == A_ACTL);
  assign ack     = bus_wr_i && (bus_addr_i == A_IRQ) && bus_wdata_i[STAT_BIT];

  // control and debounce registers
  assign stop_en = bus_wr_i && unlocked && (bus_addr_i == A_CTRL);
  assign stop_d  = bus_wdata_i[0];
  assign deb_en  = bus_wr_i && unlocked && (bus_addr_i == A_DEB);
  assign deb_d   = bus_wdata_i[DEB_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stop_q <= 1'b1;
    else if (stop_en) stop_q <= stop_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      deb_q <= '0;
    else if (deb_en) deb_q <= deb_d;
  end

  cal_rtc_time #(.FIELD_W(FIELD_W), .YEAR_MAX(YEAR_MAX)) u_time (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .run_i      (unlocked && !stop_q),
    .wr_en_i    (time_wr),
    .wr_field_i (fidx),
    .wr_data_i  (bus_wdata_i[FIELD_W-1:0]),
    .time_o     (time_q),
    .adv_o      (adv)
  );

  cal_rtc_alarm #(.FIELD_W(FIELD_W)) u_alarm (
    .clk          (clk),
    .rst_n        (rst_n),
    .time_i       (time_q),
    .adv_i        (adv),
    .bank_wr_i    (alm_wr),
    .bank_field_i (fidx),
    .bank_data_i  (bus_wdata_i[FIELD_W-1:0]),
    .ctl_wr_i     (ctl_wr),
    .ctl_data_i   (bus_wdata_i[CTL_W-1:0]),
    .ack_i        (ack),
    .alarm_o      (alm_q),
    .ctl_o        (ctl),
    .status_o     (status),
    .irq_o        (irq_o)
  );

  // read decode
  always_comb begin
    rdata = '0;
    if (bus_addr_i == A_CTRL)      rdata[0] = stop_q;
    else if (bus_addr_i == A_DEB)  rdata[DEB_W-1:0] = deb_q;
    else if (bus_addr_i == A_IRQ)  rdata[STAT_BIT] = status;
    else if (bus_addr_i == A_ACTL) rdata[CTL_W-1:0] = ctl;
    else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (hit_time[i]) rdata[FIELD_W-1:0] = time_q[i];
        if (hit_alm[i])  rdata[FIELD_W-1:0] = alm_q[i];
      end
    end
  end

  assign bus_rdata_o = rdata;

  // R2: writes while locked leave control and debounce untouched
  assert_locked_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && bus_wr_i) |=> ($stable(stop_q) && $stable(deb_q) && $stable(ctl)))
    else $error("locked write took effect");

endmodule

// File: tb/cal_rtc_bench.sv
module cal_rtc_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk;
  int n_fail;
  bit done;

  // entry: start time [111:56], expected after one tick [55:0]
  // bytes: year, month, day of month, day of week, hour, minute, second
  localparam logic [111:0] VECS [NVEC] = '{
    {8'd0, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0,      8'd0, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0, 8'd1},
    {8'd23,8'd5, 8'd14,8'd2, 8'd10,8'd59,8'd59,     8'd23,8'd5, 8'd14,8'd2, 8'd11,8'd0, 8'd0},
    {8'd21,8'd4, 8'd30,8'd3, 8'd23,8'd59,8'd59,     8'd21,8'd5, 8'd1, 8'd4, 8'd0, 8'd0, 8'd0},
    {8'd21,8'd1, 8'd31,8'd6, 8'd23,8'd59,8'd59,     8'd21,8'd2, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0},
    {8'd21,8'd2, 8'd28,8'd1, 8'd23,8'd59,8'd59,     8'd21,8'd3, 8'd1, 8'd2, 8'd0, 8'd0, 8'd0},
    {8'd24,8'd2, 8'd28,8'd3, 8'd23,8'd59,8'd59,     8'd24,8'd2, 8'd29,8'd4, 8'd0, 8'd0, 8'd0},
    {8'd24,8'd2, 8'd29,8'd4, 8'd23,8'd59,8'd59,     8'd24,8'd3, 8'd1, 8'd5, 8'd0, 8'd0, 8'd0},
    {8'd0, 8'd2, 8'd28,8'd1, 8'd23,8'd59,8'd59,     8'd0, 8'd3, 8'd1, 8'd2, 8'd0, 8'd0, 8'd0},
    {8'd99,8'd12,8'd31,8'd5, 8'd23,8'd59,8'd59,     8'd0, 8'd1, 8'd1, 8'd6, 8'd0, 8'd0, 8'd0},
    {8'd10,8'd6, 8'd30,8'd6, 8'd23,8'd59,8'd59,     8'd10,8'd7, 8'd1, 8'd0, 8'd0, 8'd0, 8'd0},
    {8'd10,8'd7, 8'd31,8'd0, 8'd22,8'd59,8'd59,     8'd10,8'd7, 8'd31,8'd0, 8'd23,8'd0, 8'd0},
    {8'd12,8'd12,8'd31,8'd2, 8'd23,8'd59,8'd59,     8'd13,8'd1, 8'd1, 8'd3, 8'd0, 8'd0, 8'd0}
  };

  cal_rtc u_cal_rtc (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic unlock_all();
    wr(8'h04, 32'hC6); wr(8'h08, 32'h9A); wr(8'h0C, 32'h59); wr(8'h10, 32'hA3);
    wr(8'h14, 32'h57); wr(8'h18, 32'h67); wr(8'h1C, 32'hD2);
  endtask

  task automatic set_time(input logic [55:0] t);
    wr(8'h20, 32'h1);
    for (int f = 0; f < 7; f++) wr(8'(8'h40 + 4*f), {24'h0, t[55-8*f -: 8]});
    wr(8'h20, 32'h0);
  endtask

  task automatic get_time(output logic [55:0] t);
    logic [31:0] d;
    for (int f = 0; f < 7; f++) begin
      rd(8'(8'h40 + 4*f), d);
      t[55-8*f -: 8] = d[7:0];
    end
  endtask

  initial begin
    #(CLK_PERIOD * 60000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual hang expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [55:0] t;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; tick = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h20, d); chk(d, 1, "R1 stop bit");
    get_time(t);  chk(t, {8'd0,8'd1,8'd1,8'd0,8'd0,8'd0,8'd0}, "R1 time bank");
    rd(8'h2C, d); chk(d, 0, "R1 debounce");
    rd(8'h30, d); chk(d, 0, "R1 status");
    rd(8'h7C, d); chk(d, 0, "R1 alarm control");
    chk(irq, 0, "R1 irq");

    // R2 locked writes are ignored
    wr(8'h20, 32'h0); rd(8'h20, d); chk(d, 1, "R2 locked stop write");
    do_tick(); rd(8'h58, d); chk(d, 0, "R2 locked no count");
    wr(8'h2C, 32'h5); rd(8'h2C, d); chk(d, 0, "R2 locked debounce");
    wr(8'h78, 32'h9); rd(8'h78, d); chk(d, 0, "R2 locked alarm field");
    wr(8'h7C, 32'hFF); rd(8'h7C, d); chk(d, 0, "R2 locked alarm control");

    // R3 wrong key restarts the sequence
    wr(8'h04, 32'hC6); wr(8'h08, 32'h9A); wr(8'h0C, 32'h59); wr(8'h10, 32'h00);
    wr(8'h14, 32'h57); wr(8'h18, 32'h67); wr(8'h1C, 32'hD2);
    wr(8'h2C, 32'h3); rd(8'h2C, d); chk(d, 0, "R3 still locked after bad key");

    // R2 full sequence unlocks, R9 debounce width
    unlock_all();
    wr(8'h2C, 32'hFF); rd(8'h2C, d); chk(d, 7, "R2 R9 debounce after unlock");
    wr(8'h2C, 32'h2); rd(8'h2C, d); chk(d, 2, "R9 debounce value");

    // R4 stop bit
    do_tick(); rd(8'h58, d); chk(d, 0, "R4 stopped tick holds");
    wr(8'h20, 32'h0); do_tick(); rd(8'h58, d); chk(d, 1, "R4 running tick advances");
    wr(8'h58, 32'd30); rd(8'h58, d); chk(d, 1, "R4 time write ignored while running");

    // R5 R6 R7 R8 calendar vectors
    for (int v = 0; v < NVEC; v++) begin
      set_time(VECS[v][111:56]);
      do_tick();
      get_time(t);
      n_chk++;
      if (t !== VECS[v][55:0]) begin
        n_fail++;
        $display("FAIL R6 R7 R8 vector %0d: actual %0h expected %0h", v, t, VECS[v][55:0]);
      end
    end

    // R10 R11 R12 alarm
    set_time({8'd5, 8'd3, 8'd10, 8'd1, 8'd0, 8'd0, 8'd10});
    wr(8'h74, 32'd1); wr(8'h78, 32'd12); wr(8'h7C, 32'hC1);
    rd(8'h78, d); chk(d, 12, "R5 alarm second readback");
    do_tick(); do_tick();
    rd(8'h30, d); chk(d, 0, "R10 partial match no status");
    repeat (59) do_tick();
    rd(8'h30, d); chk(d, 0, "R10 not yet matched");
    do_tick();
    rd(8'h30, d); chk(d, 32'h10, "R10 status on full match");
    chk(irq, 1, "R12 irq asserted");
    wr(8'h30, 32'h0); rd(8'h30, d); chk(d, 32'h10, "R11 write 0 keeps status");
    wr(8'h7C, 32'h0); rd(8'h30, d); chk(d, 32'h10, "R12 status kept after disable");
    chk(irq, 0, "R12 irq dropped after disable");
    wr(8'h30, 32'h10); rd(8'h30, d); chk(d, 0, "R11 write 1 clears status");
    wr(8'h7C, 32'h01); do_tick();
    rd(8'h30, d); chk(d, 32'h10, "R10 no compare fields matches any tick");
    wr(8'h30, 32'h10);
    wr(8'h78, 32'd14); wr(8'h7C, 32'h80); do_tick();
    rd(8'h58, d); chk(d, 14, "R10 second reached alarm");
    rd(8'h30, d); chk(d, 0, "R10 master disabled no status");
    chk(irq, 0, "R12 irq low when master disabled");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule